// File: doc/BRIEF.md
# Segmented Linear Interpolator

This block computes a piecewise-linear output, one sample at a time, for a small set of channels. Each channel holds one line segment. The segment is defined by a full-precision base value Y1, an origin X1, a slope W1, a right-shift scale S, and two validity limits X2 and X3. For each sample X the block forms Y = Y1 + ((W1 * (X - X1)) >>> S). The slope term is always built from the offset X - X1. It is a small correction added to Y1, and it is never folded into a precomputed intercept. The block also flags a sample that lies outside [X2, X3]. When the sum does not fit the output range, the result is clamped.

Each channel can instead run in delay mode. In that mode the sample input carries an integrator value T, and the result is Y1 + ((D*K) >>> S) + ((D*(T-K)) >>> S), where D = Y2 - Y1 and K is a per-channel constant. The two partial terms are scaled separately.

Software writes segment parameters into per-channel shadow registers. A commit strobe copies a channel's shadow set into its active set in one step, but only after the set passes a consistency check. A set that fails the check is refused and reported.

Top module: `seg_interp`

## Requirements
- R1: In linear mode (mode bit 0), a sample X on channel c produces Y = Y1 + ((W1*(X-X1)) >>> S). Here >>> is an arithmetic right shift that rounds toward minus infinity, and all terms come from channel c's active segment.
- R2: The out-of-range flag is 1 exactly when X < X2 or X > X3, with signed comparison. The value Y is still produced for an out-of-range sample.
- R3: When the exact result exceeds 16383 the output is 16383, and when it is below -16384 the output is -16384. In both cases the overflow flag is 1; otherwise the flag is 0.
- R4: Y1, Y2 and Y are 15-bit two's complement. X, X1, W1, X2, X3 and K are 10-bit two's complement. S is a 3-bit unsigned shift count from 0 to 7.
- R5: A configuration write changes only the shadow set of the addressed channel. The output is unaffected until a commit for that channel. A commit copies all fields to the active set together, and other channels are untouched.
- R6: A commit is refused when X2 > X3, or when in linear mode X2 <= X1 <= X3. A refused commit leaves the active set unchanged, and the reject output is 1 in the cycle after the commit cycle. In delay mode X1 is not checked.
- R7: In delay mode (mode bit 1), the sample value is taken as T and Y = Y1 + ((D*K) >>> S) + ((D*(T-K)) >>> S), with D = Y2 - Y1 computed at 16 bits.
- R8: A sample accepted at a clock edge appears on the outputs after the third rising edge, counting the accepting edge. The output valid is 1 for that one cycle, and the output channel tag equals the sample's channel.
- R9: After reset the output valid, value and flags are 0. The value and flags hold between valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write shadow set of cfg_ch_i |
| cfg_ch_i | input | CHW | Channel addressed by the write |
| cfg_mode_i | input | 1 | 0 linear, 1 delay |
| cfg_y1_i | input | YW | Base value Y1 |
| cfg_y2_i | input | YW | Delay-mode end value Y2 |
| cfg_x1_i | input | XW | Origin X1 |
| cfg_w1_i | input | XW | Slope W1 |
| cfg_x2_i | input | XW | Lower limit X2 |
| cfg_x3_i | input | XW | Upper limit X3 |
| cfg_k_i | input | XW | Delay-mode constant K |
| cfg_shift_i | input | SHW | Right-shift scale S |
| commit_i | input | 1 | Copy shadow to active for commit_ch_i |
| commit_ch_i | input | CHW | Channel to commit |
| cfg_reject_o | output | 1 | Previous commit was refused |
| smp_valid_i | input | 1 | Sample present |
| smp_ch_i | input | CHW | Sample channel |
| smp_x_i | input | XW | Sample X (or T in delay mode) |
| out_valid_o | output | 1 | Result present |
| out_ch_o | output | CHW | Result channel |
| out_y_o | output | YW | Result Y |
| out_range_o | output | 1 | Sample was outside [X2, X3] |
| out_ovf_o | output | 1 | Result was clamped |

## Verification
The latency and tag properties assume that the sample inputs are driven to known values in every cycle from reset release onward. They do not assume any particular sample rate. The stimulus keeps smp_valid_i at 0 during reset and between samples, and it always drives a legal channel number. No property depends on configuration legality, because the block itself screens every commit. The stimulus deliberately issues commits that must be refused, both by limit order and by the position of the origin.

// File: rtl/seg_interp_pkg.sv
`timescale 1ns/1ps
package seg_interp_pkg;
  localparam int unsigned NCH_DEF = 4;
  localparam int unsigned YW_DEF  = 15;
  localparam int unsigned XW_DEF  = 10;
  localparam int unsigned SHW_DEF = 3;

  typedef enum logic {
    SEG_LINEAR = 1'b0,
    SEG_DELAY  = 1'b1
  } seg_mode_e;
endpackage

// File: rtl/seg_interp_bank.sv
`timescale 1ns/1ps
module seg_interp_bank
  import seg_interp_pkg::*;
#(
  parameter int unsigned N_CH = NCH_DEF,
  parameter int unsigned YW   = YW_DEF,
  parameter int unsigned XW   = XW_DEF,
  parameter int unsigned SHW  = SHW_DEF,
  parameter int unsigned CHW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CHW-1:0]        cfg_ch_i,
  input  seg_mode_e             cfg_mode_i,
  input  logic signed [YW-1:0]  cfg_y1_i,
  input  logic signed [YW-1:0]  cfg_y2_i,
  input  logic signed [XW-1:0]  cfg_x1_i,
  input  logic signed [XW-1:0]  cfg_w1_i,
  input  logic signed [XW-1:0]  cfg_x2_i,
  input  logic signed [XW-1:0]  cfg_x3_i,
  input  logic signed [XW-1:0]  cfg_k_i,
  input  logic [SHW-1:0]        cfg_shift_i,
  input  logic                  commit_i,
  input  logic [CHW-1:0]        commit_ch_i,
  output logic                  reject_o,
  input  logic [CHW-1:0]        rd_ch_i,
  output seg_mode_e             rd_mode_o,
  output logic signed [YW-1:0]  rd_y1_o,
  output logic signed [YW-1:0]  rd_y2_o,
  output logic signed [XW-1:0]  rd_x1_o,
  output logic signed [XW-1:0]  rd_w1_o,
  output logic signed [XW-1:0]  rd_x2_o,
  output logic signed [XW-1:0]  rd_x3_o,
  output logic signed [XW-1:0]  rd_k_o,
  output logic [SHW-1:0]        rd_shift_o
);
  // shadow set
  seg_mode_e            sh_mode [N_CH];
  logic signed [YW-1:0] sh_y1   [N_CH];
  logic signed [YW-1:0] sh_y2   [N_CH];
  logic signed [XW-1:0] sh_x1   [N_CH];
  logic signed [XW-1:0] sh_w1   [N_CH];
  logic signed [XW-1:0] sh_x2   [N_CH];
  logic signed [XW-1:0] sh_x3   [N_CH];
  logic signed [XW-1:0] sh_k    [N_CH];
  logic [SHW-1:0]       sh_sh   [N_CH];
  // active set
  seg_mode_e            ac_mode [N_CH];
  logic signed [YW-1:0] ac_y1   [N_CH];
  logic signed [YW-1:0] ac_y2   [N_CH];
  logic signed [XW-1:0] ac_x1   [N_CH];
  logic signed [XW-1:0] ac_w1   [N_CH];
  logic signed [XW-1:0] ac_x2   [N_CH];
  logic signed [XW-1:0] ac_x3   [N_CH];
  logic signed [XW-1:0] ac_k    [N_CH];
  logic [SHW-1:0]       ac_sh   [N_CH];

  logic signed [XW-1:0] ck_x1, ck_x2, ck_x3;
  seg_mode_e            ck_mode;
  logic                 order_ok, origin_ok, cmt_ok;

  // screen the shadow set being committed
  always_comb begin
    ck_mode   = sh_mode[commit_ch_i];
    ck_x1     = sh_x1[commit_ch_i];
    ck_x2     = sh_x2[commit_ch_i];
    ck_x3     = sh_x3[commit_ch_i];
    order_ok  = (ck_x2 <= ck_x3);
    origin_ok = (ck_x1 < ck_x2) || (ck_x1 > ck_x3);
    cmt_ok    = order_ok && ((ck_mode == SEG_DELAY) || origin_ok);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic wr_hit, cm_hit;
    assign wr_hit = cfg_we_i && (cfg_ch_i == CHW'(c));
    assign cm_hit = commit_i && (commit_ch_i == CHW'(c)) && cmt_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_mode[c] <= SEG_LINEAR;
        sh_y1[c]   <= '0;
        sh_y2[c]   <= '0;
        sh_x1[c]   <= '0;
        sh_w1[c]   <= '0;
        sh_x2[c]   <= '0;
        sh_x3[c]   <= '0;
        sh_k[c]    <= '0;
        sh_sh[c]   <= '0;
      end else if (wr_hit) begin
        sh_mode[c] <= cfg_mode_i;
        sh_y1[c]   <= cfg_y1_i;
        sh_y2[c]   <= cfg_y2_i;
        sh_x1[c]   <= cfg_x1_i;
        sh_w1[c]   <= cfg_w1_i;
        sh_x2[c]   <= cfg_x2_i;
        sh_x3[c]   <= cfg_x3_i;
        sh_k[c]    <= cfg_k_i;
        sh_sh[c]   <= cfg_shift_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ac_mode[c] <= SEG_LINEAR;
        ac_y1[c]   <= '0;
        ac_y2[c]   <= '0;
        ac_x1[c]   <= '0;
        ac_w1[c]   <= '0;
        ac_x2[c]   <= '0;
        ac_x3[c]   <= '0;
        ac_k[c]    <= '0;
        ac_sh[c]   <= '0;
      end else if (cm_hit) begin
        ac_mode[c] <= sh_mode[c];
        ac_y1[c]   <= sh_y1[c];
        ac_y2[c]   <= sh_y2[c];
        ac_x1[c]   <= sh_x1[c];
        ac_w1[c]   <= sh_w1[c];
        ac_x2[c]   <= sh_x2[c];
        ac_x3[c]   <= sh_x3[c];
        ac_k[c]    <= sh_k[c];
        ac_sh[c]   <= sh_sh[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_o <= 1'b0;
    else         reject_o <= commit_i && !cmt_ok;
  end

  always_comb begin
    rd_mode_o  = ac_mode[rd_ch_i];
    rd_y1_o    = ac_y1[rd_ch_i];
    rd_y2_o    = ac_y2[rd_ch_i];
    rd_x1_o    = ac_x1[rd_ch_i];
    rd_w1_o    = ac_w1[rd_ch_i];
    rd_x2_o    = ac_x2[rd_ch_i];
    rd_x3_o    = ac_x3[rd_ch_i];
    rd_k_o     = ac_k[rd_ch_i];
    rd_shift_o = ac_sh[rd_ch_i];
  end
endmodule

// File: rtl/seg_interp_sat.sv
`timescale 1ns/1ps
module seg_interp_sat #(
  parameter int unsigned IW = 29,
  parameter int unsigned OW = 15
) (
  input  logic signed [IW-1:0] val_i,
  output logic signed [OW-1:0] val_o,
  output logic                 clip_o
);
  localparam logic signed [IW-1:0] HI_W = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] LO_W = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};
  localparam logic signed [OW-1:0] HI_N = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] LO_N = {1'b1, {(OW-1){1'b0}}};

  always_comb begin
    if (val_i > HI_W) begin
      val_o  = HI_N;
      clip_o = 1'b1;
    end else if (val_i < LO_W) begin
      val_o  = LO_N;
      clip_o = 1'b1;
    end else begin
      val_o  = val_i[OW-1:0];
      clip_o = 1'b0;
    end
  end
endmodule

// File: rtl/seg_interp_pipe.sv
`timescale 1ns/1ps
module seg_interp_pipe
  import seg_interp_pkg::*;
#(
  parameter int unsigned CHW = 2,
  parameter int unsigned YW  = YW_DEF,
  parameter int unsigned XW  = XW_DEF,
  parameter int unsigned SHW = SHW_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_valid_i,
  input  logic [CHW-1:0]       smp_ch_i,
  input  logic signed [XW-1:0] smp_x_i,
  input  seg_mode_e            seg_mode_i,
  input  logic signed [YW-1:0] seg_y1_i,
  input  logic signed [YW-1:0] seg_y2_i,
  input  logic signed [XW-1:0] seg_x1_i,
  input  logic signed [XW-1:0] seg_w1_i,
  input  logic signed [XW-1:0] seg_x2_i,
  input  logic signed [XW-1:0] seg_x3_i,
  input  logic signed [XW-1:0] seg_k_i,
  input  logic [SHW-1:0]       seg_shift_i,
  output logic                 out_valid_o,
  output logic [CHW-1:0]       out_ch_o,
  output logic signed [YW-1:0] out_y_o,
  output logic                 out_range_o,
  output logic                 out_ovf_o
);
  localparam int unsigned AW = YW + 1;  // multiplicand: slope or Y2-Y1
  localparam int unsigned BW = XW + 1;  // multiplier: offset from origin or K
  localparam int unsigned PW = AW + BW;
  localparam int unsigned SW = PW + 1;
  localparam int unsigned TW = SW + 1;

  // stage 1: offsets, operand select, range check
  logic signed [AW-1:0] d_w, w1e_w, a_w;
  logic signed [BW-1:0] xe_w, x1e_w, ke_w, b_w, c_w;
  logic                 rng_w;

  always_comb begin
    d_w   = {seg_y2_i[YW-1], seg_y2_i} - {seg_y1_i[YW-1], seg_y1_i};
    w1e_w = {{(AW-XW){seg_w1_i[XW-1]}}, seg_w1_i};
    xe_w  = {smp_x_i[XW-1], smp_x_i};
    x1e_w = {seg_x1_i[XW-1], seg_x1_i};
    ke_w  = {seg_k_i[XW-1], seg_k_i};
    rng_w = (smp_x_i < seg_x2_i) || (smp_x_i > seg_x3_i);
    if (seg_mode_i == SEG_DELAY) begin
      a_w = d_w;
      b_w = xe_w - ke_w;
      c_w = ke_w;
    end else begin
      a_w = w1e_w;
      b_w = xe_w - x1e_w;
      c_w = '0;
    end
  end

  logic                 s1_v, s1_rng;
  logic [CHW-1:0]       s1_ch;
  logic signed [AW-1:0] s1_a;
  logic signed [BW-1:0] s1_b, s1_c;
  logic [SHW-1:0]       s1_sh;
  logic signed [YW-1:0] s1_y1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_rng <= 1'b0;
      s1_ch  <= '0;
      s1_a   <= '0;
      s1_b   <= '0;
      s1_c   <= '0;
      s1_sh  <= '0;
      s1_y1  <= '0;
    end else begin
      s1_v <= smp_valid_i;
      if (smp_valid_i) begin
        s1_rng <= rng_w;
        s1_ch  <= smp_ch_i;
        s1_a   <= a_w;
        s1_b   <= b_w;
        s1_c   <= c_w;
        s1_sh  <= seg_shift_i;
        s1_y1  <= seg_y1_i;
      end
    end
  end

  // stage 2: two products, each scaled on its own
  logic signed [PW-1:0] ae_w, be_w, ce_w, pb_w, pc_w, qb_w, qc_w;
  logic signed [SW-1:0] sum_w;

  always_comb begin
    ae_w  = {{BW{s1_a[AW-1]}}, s1_a};
    be_w  = {{AW{s1_b[BW-1]}}, s1_b};
    ce_w  = {{AW{s1_c[BW-1]}}, s1_c};
    pb_w  = ae_w * be_w;
    pc_w  = ae_w * ce_w;
    qb_w  = pb_w >>> s1_sh;
    qc_w  = pc_w >>> s1_sh;
    sum_w = {qb_w[PW-1], qb_w} + {qc_w[PW-1], qc_w};
  end

  logic                 s2_v, s2_rng;
  logic [CHW-1:0]       s2_ch;
  logic signed [SW-1:0] s2_sum;
  logic signed [YW-1:0] s2_y1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v   <= 1'b0;
      s2_rng <= 1'b0;
      s2_ch  <= '0;
      s2_sum <= '0;
      s2_y1  <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_rng <= s1_rng;
        s2_ch  <= s1_ch;
        s2_sum <= sum_w;
        s2_y1  <= s1_y1;
      end
    end
  end

  // stage 3: add the full-precision base, clamp
  logic signed [TW-1:0] tot_w;
  logic signed [YW-1:0] y_sat_w;
  logic                 clip_w;

  assign tot_w = {s2_sum[SW-1], s2_sum} + {{(TW-YW){s2_y1[YW-1]}}, s2_y1};

  seg_interp_sat #(
    .IW(TW),
    .OW(YW)
  ) u_sat (
    .val_i (tot_w),
    .val_o (y_sat_w),
    .clip_o(clip_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_ch_o    <= '0;
      out_y_o     <= '0;
      out_range_o <= 1'b0;
      out_ovf_o   <= 1'b0;
    end else begin
      out_valid_o <= s2_v;
      if (s2_v) begin
        out_ch_o    <= s2_ch;
        out_y_o     <= y_sat_w;
        out_range_o <= s2_rng;
        out_ovf_o   <= clip_w;
      end
    end
  end
endmodule

// File: rtl/seg_interp.sv
`timescale 1ns/1ps
module seg_interp
  import seg_interp_pkg::*;
#(
  parameter int unsigned N_CH = NCH_DEF,
  parameter int unsigned YW   = YW_DEF,
  parameter int unsigned XW   = XW_DEF,
  parameter int unsigned SHW  = SHW_DEF,
  localparam int unsigned CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CHW-1:0]       cfg_ch_i,
  input  logic                 cfg_mode_i,
  input  logic signed [YW-1:0] cfg_y1_i,
  input  logic signed [YW-1:0] cfg_y2_i,
  input  logic signed [XW-1:0] cfg_x1_i,
  input  logic signed [XW-1:0] cfg_w1_i,
  input  logic signed [XW-1:0] cfg_x2_i,
  input  logic signed [XW-1:0] cfg_x3_i,
  input  logic signed [XW-1:0] cfg_k_i,
  input  logic [SHW-1:0]       cfg_shift_i,
  input  logic                 commit_i,
  input  logic [CHW-1:0]       commit_ch_i,
  output logic                 cfg_reject_o,
  input  logic                 smp_valid_i,
  input  logic [CHW-1:0]       smp_ch_i,
  input  logic signed [XW-1:0] smp_x_i,
  output logic                 out_valid_o,
  output logic [CHW-1:0]       out_ch_o,
  output logic signed [YW-1:0] out_y_o,
  output logic                 out_range_o,
  output logic                 out_ovf_o
);
  seg_mode_e            rd_mode;
  logic signed [YW-1:0] rd_y1, rd_y2;
  logic signed [XW-1:0] rd_x1, rd_w1, rd_x2, rd_x3, rd_k;
  logic [SHW-1:0]       rd_shift;

  seg_interp_bank #(
    .N_CH(N_CH),
    .YW  (YW),
    .XW  (XW),
    .SHW (SHW),
    .CHW (CHW)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_ch_i   (cfg_ch_i),
    .cfg_mode_i (seg_mode_e'(cfg_mode_i)),
    .cfg_y1_i   (cfg_y1_i),
    .cfg_y2_i   (cfg_y2_i),
    .cfg_x1_i   (cfg_x1_i),
    .cfg_w1_i   (cfg_w1_i),
    .cfg_x2_i   (cfg_x2_i),
    .cfg_x3_i   (cfg_x3_i),
    .cfg_k_i    (cfg_k_i),
    .cfg_shift_i(cfg_shift_i),
    .commit_i   (commit_i),
    .commit_ch_i(commit_ch_i),
    .reject_o   (cfg_reject_o),
    .rd_ch_i    (smp_ch_i),
    .rd_mode_o  (rd_mode),
    .rd_y1_o    (rd_y1),
    .rd_y2_o    (rd_y2),
    .rd_x1_o    (rd_x1),
    .rd_w1_o    (rd_w1),
    .rd_x2_o    (rd_x2),
    .rd_x3_o    (rd_x3),
    .rd_k_o     (rd_k),
    .rd_shift_o (rd_shift)
  );

  seg_interp_pipe #(
    .CHW(CHW),
    .YW (YW),
    .XW (XW),
    .SHW(SHW)
  ) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_valid_i(smp_valid_i),
    .smp_ch_i   (smp_ch_i),
    .smp_x_i    (smp_x_i),
    .seg_mode_i (rd_mode),
    .seg_y1_i   (rd_y1),
    .seg_y2_i   (rd_y2),
    .seg_x1_i   (rd_x1),
    .seg_w1_i   (rd_w1),
    .seg_x2_i   (rd_x2),
    .seg_x3_i   (rd_x3),
    .seg_k_i    (rd_k),
    .seg_shift_i(rd_shift),
    .out_valid_o(out_valid_o),
    .out_ch_o   (out_ch_o),
    .out_y_o    (out_y_o),
    .out_range_o(out_range_o),
    .out_ovf_o  (out_ovf_o)
  );
endmodule

// File: rtl/seg_interp_chk.sv
`timescale 1ns/1ps
module seg_interp_chk #(
  parameter int unsigned CHW = 2,
  parameter int unsigned YW  = 15
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 commit_i,
  input logic                 cfg_reject_o,
  input logic                 smp_valid_i,
  input logic [CHW-1:0]       smp_ch_i,
  input logic                 out_valid_o,
  input logic [CHW-1:0]       out_ch_o,
  input logic signed [YW-1:0] out_y_o,
  input logic                 out_ovf_o
);
  localparam logic signed [YW-1:0] Y_HI = {1'b0, {(YW-1){1'b1}}};
  localparam logic signed [YW-1:0] Y_LO = {1'b1, {(YW-1){1'b0}}};

  // edges seen since reset release, saturating at the pipeline depth
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= 2'd0;
    else if (seen_q != 2'd3)  seen_q <= seen_q + 2'd1;
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd3) |-> (out_valid_o == $past(smp_valid_i, 3)));

  p_tag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen_q == 2'd3) && out_valid_o) |-> (out_ch_o == $past(smp_ch_i, 3)));

  p_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ovf_o |-> ((out_y_o == Y_HI) || (out_y_o == Y_LO)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(out_y_o) && $stable(out_ovf_o)));

  p_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reject_o |-> $past(commit_i));
endmodule

bind seg_interp seg_interp_chk #(
  .CHW(CHW),
  .YW (YW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .commit_i    (commit_i),
  .cfg_reject_o(cfg_reject_o),
  .smp_valid_i (smp_valid_i),
  .smp_ch_i    (smp_ch_i),
  .out_valid_o (out_valid_o),
  .out_ch_o    (out_ch_o),
  .out_y_o     (out_y_o),
  .out_ovf_o   (out_ovf_o)
);

// File: tb/seg_interp_bench.sv
`timescale 1ns/1ps
module seg_interp_bench;
  localparam int NCH = 4;
  localparam int CW  = 2;
  localparam int YB  = 15;
  localparam int XB  = 10;
  localparam int SB  = 3;
  localparam int NV  = 10;
  // columns: mode y1 y2 x1 w1 x2 x3 k s x | exp_range exp_ovf
  localparam int VT [NV][12] = '{
    '{0,   1000,    0,  -10,   20,    0, 100,  0, 2,  50, 0, 0},
    '{0,  -2000,    0,  -50,  -37,  -40, 200,  0, 0, 150, 0, 0},
    '{0,    500,    0,  300,   15, -100, 100,  0, 1, -20, 0, 0},
    '{0,   1000,    0,  -10,   20,    0, 100,  0, 2, 150, 1, 0},
    '{0,  16000,    0, -500,  511,    0, 500,  0, 0, 400, 0, 1},
    '{0, -16000,    0, -500, -512,    0, 500,  0, 0, 400, 0, 1},
    '{1,    100, 1100,    0,    0, -100, 100, 64, 7,  32, 0, 0},
    '{1,      0,   -3,    0,    0,    0,  10,  1, 1,   4, 0, 0},
    '{0,      0,    0,    0,   -1,    1,  10,  0, 1,   3, 0, 0},
    '{0,   1000,    0,  -10,   20,    0, 100,  0, 2,  -5, 1, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_mode = 1'b0, commit = 1'b0, smp_valid = 1'b0;
  logic [CW-1:0] cfg_ch = '0, commit_ch = '0, smp_ch = '0;
  logic signed [YB-1:0] cfg_y1 = '0, cfg_y2 = '0;
  logic signed [XB-1:0] cfg_x1 = '0, cfg_w1 = '0, cfg_x2 = '0, cfg_x3 = '0, cfg_k = '0, smp_x = '0;
  logic [SB-1:0] cfg_sh = '0;
  logic cfg_reject, out_valid, out_range, out_ovf;
  logic [CW-1:0] out_ch;
  logic signed [YB-1:0] out_y;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  seg_interp #(.N_CH(NCH), .YW(YB), .XW(XB), .SHW(SB)) u_seg_interp (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_mode_i(cfg_mode),
    .cfg_y1_i(cfg_y1), .cfg_y2_i(cfg_y2), .cfg_x1_i(cfg_x1), .cfg_w1_i(cfg_w1),
    .cfg_x2_i(cfg_x2), .cfg_x3_i(cfg_x3), .cfg_k_i(cfg_k), .cfg_shift_i(cfg_sh),
    .commit_i(commit), .commit_ch_i(commit_ch), .cfg_reject_o(cfg_reject),
    .smp_valid_i(smp_valid), .smp_ch_i(smp_ch), .smp_x_i(smp_x),
    .out_valid_o(out_valid), .out_ch_o(out_ch), .out_y_o(out_y),
    .out_range_o(out_range), .out_ovf_o(out_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int mode, input int y1, input int y2, input int x1,
                               input int w1, input int k, input int s, input int x,
                               output bit ovf);
    int t, d;
    if (mode == 0) begin
      t = y1 + ((w1 * (x - x1)) >>> s);
    end else begin
      d = y2 - y1;
      t = y1 + ((d * k) >>> s) + ((d * (x - k)) >>> s);
    end
    ovf = 1'b0;
    if (t > 16383) begin t = 16383; ovf = 1'b1; end
    if (t < -16384) begin t = -16384; ovf = 1'b1; end
    return t;
  endfunction

  task automatic program_seg(input int ch, input int mode, input int y1, input int y2,
                             input int x1, input int w1, input int x2, input int x3,
                             input int k, input int s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CW'(ch); cfg_mode = mode[0];
    cfg_y1 = YB'(y1); cfg_y2 = YB'(y2); cfg_x1 = XB'(x1); cfg_w1 = XB'(w1);
    cfg_x2 = XB'(x2); cfg_x3 = XB'(x3); cfg_k = XB'(k); cfg_sh = SB'(s);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_commit(input int ch, output bit rej);
    @(negedge clk);
    commit = 1'b1; commit_ch = CW'(ch);
    @(negedge clk);
    rej = cfg_reject;
    commit = 1'b0;
  endtask

  // drives one sample; returns valid seen after edge 2 and outputs after edge 3
  task automatic take(input int ch, input int x, output bit early, output int y,
                      output bit rng, output bit ovf, output int och, output bit v);
    @(negedge clk);
    smp_valid = 1'b1; smp_ch = CW'(ch); smp_x = XB'(x);
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    early = out_valid;
    @(negedge clk);
    v = out_valid; y = int'(out_y); rng = out_range; ovf = out_ovf; och = int'(out_ch);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit early, v, rng, ovf, rej, eovf;
    int y, och, ey, y_hold;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_y == '0 && out_ovf == 1'b0 && out_range == 1'b0,
        "R9 reset outputs", int'(out_y), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk on channel 0: R1 R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      program_seg(0, VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4],
                  VT[i][5], VT[i][6], VT[i][7], VT[i][8]);
      do_commit(0, rej);
      chk(rej == 1'b0, "R6 legal commit accepted", int'(rej), 0);
      ey = model(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][7], VT[i][8], VT[i][9], eovf);
      take(0, VT[i][9], early, y, rng, ovf, och, v);
      chk(early == 1'b0 && v == 1'b1, "R8 latency three edges", int'(v), 1);
      chk(och == 0, "R8 channel tag", och, 0);
      chk(y == ey, VT[i][0] == 1 ? "R7 delay-mode value" : "R1 R4 linear value", y, ey);
      chk(rng == VT[i][10][0], "R2 range flag", int'(rng), VT[i][10]);
      chk(ovf == VT[i][11][0] && ovf == eovf, "R3 overflow flag", int'(ovf), VT[i][11]);
    end

    // R9 hold between valid cycles
    y_hold = y;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && int'(out_y) == y_hold, "R9 output holds", int'(out_y), y_hold);

    // R5 shadow versus active, channel 1
    program_seg(1, 0, 3000, 0, -100, 10, -50, 50, 0, 0);
    do_commit(1, rej);
    take(1, 0, early, y, rng, ovf, och, v);
    chk(y == 4000 && och == 1, "R5 first commit active", y, 4000);
    program_seg(1, 0, -500, 0, 200, 4, 0, 150, 0, 2);
    take(1, 0, early, y, rng, ovf, och, v);
    chk(y == 4000, "R5 shadow write without commit ignored", y, 4000);
    do_commit(1, rej);
    take(1, 0, early, y, rng, ovf, och, v);
    chk(y == -700, "R5 commit applies new set", y, -700);
    // channel 0 unchanged: last table entry's segment
    take(0, 50, early, y, rng, ovf, och, v);
    chk(y == 1300 && och == 0, "R5 other channel untouched", y, 1300);

    // R6 refused commits keep the active set
    program_seg(1, 0, 0, 0, 50, 1, 0, 100, 0, 0);
    do_commit(1, rej);
    chk(rej == 1'b1, "R6 origin inside limits refused", int'(rej), 1);
    @(negedge clk);
    chk(cfg_reject == 1'b0, "R6 reject is one cycle", int'(cfg_reject), 0);
    take(1, 0, early, y, rng, ovf, och, v);
    chk(y == -700, "R6 refused origin keeps active", y, -700);
    program_seg(1, 0, 0, 0, -10, 1, 100, 0, 0, 0);
    do_commit(1, rej);
    chk(rej == 1'b1, "R6 reversed limits refused", int'(rej), 1);
    take(1, 0, early, y, rng, ovf, och, v);
    chk(y == -700, "R6 refused order keeps active", y, -700);
    // delay mode ignores origin position
    program_seg(1, 1, 0, 8, 5, 0, 0, 10, 0, 3);
    do_commit(1, rej);
    chk(rej == 1'b0, "R6 delay mode origin not checked", int'(rej), 0);
    take(1, 4, early, y, rng, ovf, och, v);
    chk(y == 4 && och == 1, "R7 delay mode after commit", y, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule